// File: doc/BRIEF.md
# Oversampling Manchester Data Recovery

This block recovers bits and byte timing from a Manchester-coded serial line. It uses only the local clock, which runs at a fixed multiple `OVS` of the bit rate. The intended settings are 10 or 16; at 5 Mb/s that means 50 or 80 MHz sampling. The raw line first passes through a two-flop synchronizer and then an edge detector. A small tracking state machine follows the edge events. After each accepted mid-bit transition it ignores the line for a hold-off interval. It then opens a three-sample window centred on the expected position of the next mid-bit transition.

The direction of an accepted transition gives the bit: rising is 1 and falling is 0. The bit is presented with a one-cycle strobe, and the sample counter restarts from that edge. This re-centring lets the receiver follow a transmitter whose clock runs slightly fast or slow. If no transition arrives by the end of the window, the block reports a loss of lock with a one-cycle pulse. It then goes back to hunting, and the next edge of any kind becomes the new timing reference. Recovered bits are shifted into a byte register with the least significant bit first, and each completed byte is presented with its own strobe.

Top module: `manch_recover`

## Requirements
- R1: While reset is held and in the first cycle after it, `bit_vld_o`, `byte_vld_o`, `lost_o` and `locked_o` are 0, and `byte_o` is 0.
- R2: The line passes through two synchronizer flops and one edge register. An accepted mid-bit transition on `line_i` that is set up before clock edge k raises `bit_vld_o` in the cycle that follows clock edge k+2.
- R3: While unlocked, the first edge of either direction is taken as the timing reference. That edge produces no bit strobe, and `locked_o` rises in the next cycle.
- R4: An accepted rising transition gives `bit_o` = 1, and an accepted falling transition gives `bit_o` = 0.
- R5: While locked, any edge that arrives less than `OVS`-1 samples after the last accepted edge is ignored. This covers the bit-boundary edges of runs of equal bits.
- R6: While locked, an edge that arrives `OVS`-1, `OVS` or `OVS`+1 samples after the last accepted edge is accepted. The count for the next window then restarts from that edge, so a steady drift of one sample per bit in either direction is tracked.
- R7: If no edge arrives by `OVS`+1 samples, `lost_o` pulses for one cycle and `locked_o` falls in the same cycle. An edge in the following cycle is taken as a new reference under R3.
- R8: `bit_vld_o` is a single-cycle pulse, exactly one for each edge accepted under R6, and it is never high at the same time as `lost_o`.
- R9: Bits are shifted in least significant bit first. In the cycle after every eighth strobe, `byte_vld_o` pulses for one cycle and `byte_o` holds those eight bits, with the first bit received in bit 0.
- R10: A loss of lock discards the partly assembled byte, so the next byte starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `OVS` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw asynchronous Manchester line |
| bit_o | output | 1 | Recovered bit, valid with `bit_vld_o` |
| bit_vld_o | output | 1 | One-cycle strobe per recovered bit |
| byte_o | output | 8 | Last assembled byte, first bit in bit 0 |
| byte_vld_o | output | 1 | One-cycle strobe per completed byte |
| locked_o | output | 1 | High while the tracker holds a timing reference |
| lost_o | output | 1 | One-cycle pulse when the expected transition is missing |

## Verification
The bench sends bytes of all zeros and all ones. These put a bit-boundary edge between every pair of bits, so a hold-off that ends too early would decode those edges as data and shift in extra bits. It sends bytes with a steady one-sample drift in each direction, and one byte whose spacing alternates between the two. A window one sample too narrow would report a loss of lock in the middle of these bytes, and a tracker that does not re-centre would drift out of the window within a few bits. It also stretches one bit by two samples in the middle of a stream. This checks that the loss of lock fires, that the partial byte is discarded and that the late edge becomes the new reference; a design that kept the stale bits would assemble a shifted byte. The bench also counts the cycles from a mid-bit transition to its strobe, to catch a synchronizer that is one flop short or one flop long.

// File: rtl/manch_pkg.sv
package manch_pkg;

    typedef enum logic [1:0] {
        TRK_HUNT   = 2'd0,
        TRK_HOLD   = 2'd1,
        TRK_SEARCH = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic seen;
        logic rising;
    } line_evt_t;

    typedef struct packed {
        logic vld;
        logic val;
    } rx_bit_t;

    function automatic int unsigned cnt_width(input int unsigned ovs);
        return $clog2(ovs + 3);
    endfunction

endpackage

// File: rtl/manch_line_sync.sv
module manch_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_i,
    output manch_pkg::line_evt_t  evt_o
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= line_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= stage_q[SYNC_STAGES-1];
    end

    always_comb begin
        evt_o.seen   = stage_q[SYNC_STAGES-1] ^ last_q;
        evt_o.rising = stage_q[SYNC_STAGES-1] & ~last_q;
    end
endmodule

// File: rtl/manch_bit_tracker.sv
module manch_bit_tracker #(
    parameter int unsigned OVS = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  manch_pkg::line_evt_t evt_i,
    output manch_pkg::rx_bit_t   bit_o,
    output logic                 locked_o,
    output logic                 lost_o
);
    import manch_pkg::*;

    localparam int unsigned CNT_W = cnt_width(OVS);
    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(OVS - 2);
    localparam logic [CNT_W-1:0] WIN_HI   = CNT_W'(OVS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept, timeout;

    always_comb begin
        accept  = evt_i.seen && (state_q == TRK_HUNT || state_q == TRK_SEARCH);
        timeout = (state_q == TRK_SEARCH) && (cnt_q == WIN_HI) && !evt_i.seen;
        state_d = state_q;
        unique case (state_q)
            TRK_HUNT:   if (accept) state_d = TRK_HOLD;
            TRK_HOLD:   if (cnt_q >= HOLD_END) state_d = TRK_SEARCH;
            TRK_SEARCH: begin
                if (accept)       state_d = TRK_HOLD;
                else if (timeout) state_d = TRK_HUNT;
            end
            default:    state_d = TRK_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TRK_HUNT;
            cnt_q     <= '0;
            bit_o.vld <= 1'b0;
            bit_o.val <= 1'b0;
            lost_o    <= 1'b0;
        end else begin
            state_q   <= state_d;
            bit_o.vld <= accept && (state_q == TRK_SEARCH);
            lost_o    <= timeout;
            if (accept) begin
                cnt_q     <= CNT_W'(1);
                bit_o.val <= evt_i.rising;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign locked_o = (state_q != TRK_HUNT);
endmodule

// File: rtl/manch_byte_pack.sv
module manch_byte_pack #(
    parameter int unsigned DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  manch_pkg::rx_bit_t bit_i,
    input  logic               flush_i,
    output logic [DATA_W-1:0]  word_o,
    output logic               word_vld_o
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_d;

    generate
        if (DATA_W == 1) begin : g_w1
            assign shreg_d = bit_i.val;
        end else begin : g_wn
            assign shreg_d = {bit_i.val, shreg_q[DATA_W-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            word_o     <= '0;
            word_vld_o <= 1'b0;
        end else begin
            word_vld_o <= 1'b0;
            if (flush_i) begin
                cnt_q <= '0;
            end else if (bit_i.vld) begin
                shreg_q <= shreg_d;
                if (cnt_q == LAST) begin
                    cnt_q      <= '0;
                    word_o     <= shreg_d;
                    word_vld_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/manch_recover.sv
module manch_recover #(
    parameter int unsigned OVS         = 10,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic              bit_o,
    output logic              bit_vld_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              locked_o,
    output logic              lost_o
);
    import manch_pkg::*;

    line_evt_t evt;
    rx_bit_t   rx_bit;

    manch_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .evt_o  (evt)
    );

    manch_bit_tracker #(.OVS(OVS)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .bit_o    (rx_bit),
        .locked_o (locked_o),
        .lost_o   (lost_o)
    );

    manch_byte_pack #(.DATA_W(DATA_W)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .bit_i      (rx_bit),
        .flush_i    (lost_o),
        .word_o     (byte_o),
        .word_vld_o (byte_vld_o)
    );

    assign bit_o     = rx_bit.val;
    assign bit_vld_o = rx_bit.vld;
endmodule

// File: rtl/manch_recover_chk.sv
module manch_recover_chk #(
    parameter int unsigned OVS = 10
) (
    input logic clk,
    input logic rst,
    input logic bit_vld_o,
    input logic byte_vld_o,
    input logic locked_o,
    input logic lost_o
);
    localparam int unsigned GW = $clog2(OVS + 4) + 1;
    localparam logic [GW-1:0] GMAX = '1;

    logic [GW-1:0] gap_q;
    logic          locked_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q         <= '0;
            locked_prev_q <= 1'b0;
        end else begin
            locked_prev_q <= locked_o;
            if (bit_vld_o || (locked_o && !locked_prev_q)) gap_q <= GW'(1);
            else if (gap_q != GMAX)                        gap_q <= gap_q + 1'b1;
        end
    end

    AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> locked_o); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |=> !bit_vld_o); // R8
    AST_STROBE_OR_LOST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_vld_o, lost_o})); // R7
    AST_LOST_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        lost_o |-> !locked_o); // R7
    AST_GAP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> (gap_q >= GW'(OVS - 1)) && (gap_q <= GW'(OVS + 1))); // R6
    AST_BYTE_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(bit_vld_o)); // R9
    AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o); // R9
endmodule

bind manch_recover manch_recover_chk #(.OVS(OVS)) u_chk (.*);

// File: tb/manch_recover_tb.sv
`timescale 1ns/1ps
module manch_recover_tb;
    localparam int unsigned OVS = 10;
    localparam int H1 = OVS / 2;
    localparam int H2 = OVS - OVS / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_i = 1'b0;
    logic       bit_o, bit_vld_o, byte_vld_o, locked_o, lost_o;
    logic [7:0] byte_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic       got_bits [0:63];
    logic [7:0] got_bytes [0:7];
    int nbits = 0, nbytes = 0, nlost = 0;

    always #2.5 clk = ~clk;

    manch_recover #(.OVS(OVS)) u_dut (
        .clk(clk), .rst(rst), .line_i(line_i),
        .bit_o(bit_o), .bit_vld_o(bit_vld_o),
        .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .locked_o(locked_o), .lost_o(lost_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_vld_o && nbits < 64) begin got_bits[nbits] = bit_o; nbits++; end
            if (byte_vld_o && nbytes < 8) begin got_bytes[nbytes] = byte_o; nbytes++; end
            if (lost_o) nlost++;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        nbits = 0; nbytes = 0; nlost = 0;
    endtask

    // park the line low and let any stray reference time out
    task automatic settle();
        line_i = 1'b0;
        wait_n(4 * OVS);
        clear_log();
    endtask

    task automatic send_bit(input logic b, input int h1, input int h2);
        line_i = ~b;
        wait_n(h1);
        line_i = b;
        wait_n(h2);
    endtask

    task automatic send_byte(input logic [7:0] v, input int h1, input int h2);
        for (int i = 0; i < 8; i++) send_bit(v[i], h1, h2);
    endtask

    task automatic check_byte_bits(input string req, input logic [7:0] v, input int base);
        for (int i = 0; i < 8; i++)
            check_eq(req, $sformatf("bit %0d", base + i), int'(got_bits[base + i]), int'(v[i]));
    endtask

    task automatic t_reset();
        check_eq("R1", "bit_vld", int'(bit_vld_o), 0);
        check_eq("R1", "byte_vld", int'(byte_vld_o), 0);
        check_eq("R1", "lost", int'(lost_o), 0);
        check_eq("R1", "locked", int'(locked_o), 0);
        check_eq("R1", "byte", int'(byte_o), 0);
    endtask

    task automatic t_latency();
        int lat = 0;
        settle();
        send_bit(1'b1, H1, H2);
        check_eq("R3", "no strobe for reference edge", nbits, 0);
        check_eq("R3", "locked after reference", int'(locked_o), 1);
        wait_n(H1);
        line_i = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (bit_vld_o && lat == 0) lat = i;
        end
        check_eq("R2", "strobe latency", lat, 3);
        check_eq("R4", "falling edge decodes 0", int'(got_bits[0]), 0);
        wait_n(3 * OVS);
        check_eq("R7", "lost after silence", nlost, 1);
        check_eq("R7", "unlocked after silence", int'(locked_o), 0);
    endtask

    task automatic t_byte(input string req, input logic [7:0] v, input int h1, input int h2);
        settle();
        send_bit(1'b1, H1, H2);
        send_byte(v, h1, h2);
        wait_n(3 * OVS);
        check_eq(req, "bit count", nbits, 8);
        check_byte_bits(req, v, 0);
        check_eq("R9", "byte count", nbytes, 1);
        check_eq("R9", "byte value", int'(got_bytes[0]), int'(v));
        check_eq(req, "single loss at end", nlost, 1);
    endtask

    task automatic t_runs();
        settle();
        send_bit(1'b1, H1, H2);
        send_byte(8'h00, H1, H2);
        send_byte(8'hFF, H1, H2);
        wait_n(3 * OVS);
        check_eq("R5", "boundary edges ignored, bit count", nbits, 16);
        check_eq("R5", "byte count", nbytes, 2);
        check_eq("R5", "zeros byte", int'(got_bytes[0]), 8'h00);
        check_eq("R5", "ones byte", int'(got_bytes[1]), 8'hFF);
        check_eq("R5", "no loss inside stream", nlost, 1);
    endtask

    task automatic t_alt_drift();
        logic [7:0] v = 8'h96;
        settle();
        send_bit(1'b1, H1, H2);
        for (int i = 0; i < 8; i++) send_bit(v[i], H1, (i % 2 == 0) ? H2 + 1 : H2 - 1);
        wait_n(3 * OVS);
        check_eq("R6", "alternating drift bit count", nbits, 8);
        check_eq("R6", "alternating drift byte", int'(got_bytes[0]), int'(v));
    endtask

    task automatic t_dropout();
        settle();
        send_bit(1'b1, H1, H2);
        send_bit(1'b1, H1, H2);
        send_bit(1'b0, H1, H2);
        send_bit(1'b1, H1, H2);
        send_bit(1'b1, H1 + 2, H2);   // mid edge two samples late
        send_byte(8'h5A, H1, H2);
        wait_n(3 * OVS);
        check_eq("R7", "loss count", nlost, 2);
        check_eq("R7", "bits (late edge is reference)", nbits, 11);
        check_eq("R10", "partial byte discarded", nbytes, 1);
        check_eq("R10", "byte after relock", int'(got_bytes[0]), 8'h5A);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        t_reset();
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_latency();
        t_byte("R4", 8'hA5, H1, H2);
        t_byte("R6", 8'h3C, H1, H2 + 1);
        t_byte("R6", 8'hC3, H1, H2 - 1);
        t_runs();
        t_alt_drift();
        t_dropout();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule